// File: doc/BRIEF.md
# Cascaded Programmable Modulus Counter

This block is a synchronous up-counter assembled from a chain of narrow binary counter slices (two 4-bit slices by default, giving an 8-bit count). All slices share one clock. Each slice passes its carry forward as the count enable of the next slice, and no slice is clocked by a carry. Every slice has its own synchronous clear, synchronous load and enable. Together they form one counter whose natural range is 0 to 255.

A fixed modulus `MODULUS` between 17 and 256 is imposed on the chained counter in one of two ways, picked by the `mode_i` input. In clear mode the counter runs from 0 up to `MODULUS-1`, and the next enabled edge clears every slice to 0. In preload mode the counter runs from `256-MODULUS` up to 255, and the full-width carry loads `256-MODULUS` into the slices, one nibble per slice. For a modulus of 193 that start value is 63, which is 0x3F: the high slice loads 0x3 and the low slice loads 0xF. A terminal-count pulse marks the last state of each cycle, so the block can also serve as a divide-by-`MODULUS` clock-enable source.

The elaboration step rejects a modulus outside 17..256. `mode_i` is meant to change only while `rst_n` is held low.

Top module: `cascaded_mod_counter`

## Requirements
- R1: While `rst_n` is high, `en_i` is high and `tc_o` is low, each rising clock edge adds exactly one to `count_o`. This includes the edges where the low slice wraps from 0xF and its carry advances the high slice (for example 0x0F to 0x10 and 0x3F to 0x40).
- R2: When `mode_i` = 0 (clear mode), the counter visits 0, 1, ..., `MODULUS-1`. The next enabled edge after `MODULUS-1` returns it to 0.
- R3: When `mode_i` = 1 (preload mode), the counter visits `256-MODULUS` through 255. The enabled edge at 255 loads `256-MODULUS`. With the default of 193 this is 63: the upper nibble is 0x3 and the lower nibble is 0xF.
- R4: `tc_o` is high in a cycle if and only if `en_i` is high and `count_o` holds the terminal value. The terminal value is `MODULUS-1` in clear mode and 255 in preload mode. Across any `MODULUS` consecutive enabled cycles, `tc_o` is therefore high exactly once.
- R5: When `en_i` is low and `rst_n` is high, `count_o` keeps its value across the clock edge and `tc_o` is low. This holds even when `count_o` sits at the terminal value.
- R6: When `rst_n` is low at a rising edge, `count_o` becomes the start value for `mode_i`: 0 in clear mode and `256-MODULUS` in preload mode. This happens whatever the value of `en_i` and whether or not the counter is at its terminal value.
- R7: Both the clear and the load are synchronous. During the cycle in which `tc_o` is high, `count_o` still shows the terminal value, and it changes only at the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all slices |
| rst_n | input | 1 | Synchronous reset, active low; forces the start value |
| en_i | input | 1 | Global count enable; low freezes every slice |
| mode_i | input | 1 | Modulus scheme: 0 = clear after `MODULUS-1`, 1 = preload `256-MODULUS` on full carry |
| count_o | output | 8 | Current count (`SLICE_W*NUM_SLICES` bits) |
| tc_o | output | 1 | Terminal-count pulse, high in the last state of each cycle while enabled |

## Verification
Synchronous reset can land in the same cycle as either a held count or a terminal wrap.

- **Reset while held.** The bench drives `rst_n` low while `en_i` is low and the counter sits mid-range. It judges the next sampled value of `count_o`: it must be the mode's start value, not the held value.
- **Reset at the terminal state.** The bench brings the counter to its terminal state, where `tc_o` is visibly high, and asserts reset on that edge. It checks that the pulse appears in that single cycle only and that the counter restarts cleanly.

The carry between slices is judged at every low-nibble rollover by comparing each sampled count against an independent model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   // Scheme used to impose the modulus on the chained slices
   typedef enum logic {
      MODE_CLEAR   = 1'b0,
      MODE_PRELOAD = 1'b1
   } mod_mode_e;

endpackage

// File: rtl/pmc_nibble_slice.sv
// One narrow counter slice: synchronous clear over load over count.
module pmc_nibble_slice #(
   parameter int SLICE_W = 4
) (
   input  logic               clk,
   input  logic               sync_clr,
   input  logic               sync_ld,
   input  logic [SLICE_W-1:0] ld_val,
   input  logic               cnt_en,
   output logic [SLICE_W-1:0] q,
   output logic               carry_o
);

   localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

   always_ff @(posedge clk) begin
      if (sync_clr)
         q <= '0;
      else if (sync_ld)
         q <= ld_val;
      else if (cnt_en)
         q <= q + ONE;
   end

   // Carry enables the next slice only when this slice is enabled and full
   assign carry_o = cnt_en & (&q);

endmodule

// File: rtl/pmc_wrap_ctrl.sv
// Decides when the whole chain clears or reloads, and flags the terminal state.
module pmc_wrap_ctrl
   import pmc_pkg::*;
#(
   parameter int                CNT_W  = 8,
   parameter logic [CNT_W-1:0]  LAST_V = '1
) (
   input  logic             rst_n,
   input  logic             en_i,
   input  mod_mode_e        mode,
   input  logic [CNT_W-1:0] count,
   input  logic             full_carry,
   output logic             clr_o,
   output logic             ld_o,
   output logic             tc_o
);

   logic term_clear;
   logic term_pre;

   always_comb begin
      term_clear = en_i & (count == LAST_V);
      term_pre   = full_carry;
      clr_o      = 1'b0;
      ld_o       = 1'b0;
      tc_o       = 1'b0;
      unique case (mode)
         MODE_CLEAR: begin
            tc_o  = term_clear;
            clr_o = ~rst_n | term_clear;
         end
         MODE_PRELOAD: begin
            tc_o  = term_pre;
            ld_o  = ~rst_n | term_pre;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/cascaded_mod_counter.sv
module cascaded_mod_counter
   import pmc_pkg::*;
#(
   parameter int SLICE_W    = 4,
   parameter int NUM_SLICES = 2,
   parameter int MODULUS    = 193
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en_i,
   input  logic                          mode_i,
   output logic [SLICE_W*NUM_SLICES-1:0] count_o,
   output logic                          tc_o
);

   localparam int               CNT_W   = SLICE_W * NUM_SLICES;
   localparam int               FULL    = 1 << CNT_W;
   localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(MODULUS - 1);
   localparam logic [CNT_W-1:0] START_V = CNT_W'(FULL - MODULUS);

   // Elaboration-time parameter checks
   if (SLICE_W < 1) begin : g_bad_width
      $error("cascaded_mod_counter: SLICE_W must be at least 1");
   end
   if (NUM_SLICES < 2) begin : g_bad_slices
      $error("cascaded_mod_counter: NUM_SLICES must be at least 2");
   end
   if (MODULUS <= (1 << SLICE_W) || MODULUS > FULL) begin : g_bad_modulus
      $error("cascaded_mod_counter: MODULUS out of range");
   end

   mod_mode_e            mode;
   logic                 chain_clr;
   logic                 chain_ld;
   logic [NUM_SLICES:0]  en_chain;
   logic [CNT_W-1:0]     count;

   assign mode        = mod_mode_e'(mode_i);
   assign en_chain[0] = en_i;

   // Carry chain: slice k counts when every slice below it is full
   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      pmc_nibble_slice #(.SLICE_W(SLICE_W)) slice_i (
         .clk      (clk),
         .sync_clr (chain_clr),
         .sync_ld  (chain_ld),
         .ld_val   (START_V[k*SLICE_W +: SLICE_W]),
         .cnt_en   (en_chain[k]),
         .q        (count[k*SLICE_W +: SLICE_W]),
         .carry_o  (en_chain[k+1])
      );
   end

   pmc_wrap_ctrl #(.CNT_W(CNT_W), .LAST_V(LAST_V)) ctrl_i (
      .rst_n      (rst_n),
      .en_i       (en_i),
      .mode       (mode),
      .count      (count),
      .full_carry (en_chain[NUM_SLICES]),
      .clr_o      (chain_clr),
      .ld_o       (chain_ld),
      .tc_o       (tc_o)
   );

   assign count_o = count;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
   parameter int CNT_W   = 8,
   parameter int MODULUS = 193
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_i,
   input logic             mode_i,
   input logic [CNT_W-1:0] count_o,
   input logic             tc_o
);

   localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(MODULUS - 1);
   localparam logic [CNT_W-1:0] START_V = CNT_W'((1 << CNT_W) - MODULUS);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic prev_rst_low = 1'b0;
   logic prev_mode    = 1'b0;

   always @(posedge clk) begin
      // R6
      if (prev_rst_low)
         reset_start_chk: assert (count_o == (prev_mode ? START_V : '0));
      prev_rst_low <= ~rst_n;
      prev_mode    <= mode_i;
   end

   // R1
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !tc_o) |=> (count_o == $past(count_o) + ONE));

   // R2
   clear_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_o && !mode_i) |=> (count_o == '0));

   // R3
   preload_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_o && mode_i) |=> (count_o == START_V));

   // R4
   idle_no_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !tc_o);

   // R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(count_o));

   // R7
   tc_at_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc_o |-> (count_o == (mode_i ? '1 : LAST_V)));

endmodule

bind cascaded_mod_counter pmc_checker #(.CNT_W(CNT_W), .MODULUS(MODULUS)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_i    (en_i),
   .mode_i  (mode_i),
   .count_o (count_o),
   .tc_o    (tc_o)
);

// File: tb/cascaded_mod_counter_tb.sv
`timescale 1ns/1ps
module cascaded_mod_counter_tb_top;

   localparam int M     = 193;
   localparam int START = 256 - M;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0;
   logic       mode_i = 1'b0;
   logic [7:0] count_o;
   logic       tc_o;

   int n_tests = 0;
   int n_fail  = 0;
   int exp_cnt = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   cascaded_mod_counter #(.SLICE_W(4), .NUM_SLICES(2), .MODULUS(M)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_i),
      .mode_i  (mode_i),
      .count_o (count_o),
      .tc_o    (tc_o)
   );

   function automatic int term_of(input logic md);
      return md ? 255 : M - 1;
   endfunction

   function automatic int start_of(input logic md);
      return md ? START : 0;
   endfunction

   task automatic check_eq(input int act, input int exp, input string what);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   // Drive one cycle, check tc before the edge and count after it
   task automatic cyc(input logic e, input logic r, input string tag);
      int exp_tc;
      en_i  = e;
      rst_n = r;
      #1;
      exp_tc = (e && exp_cnt == term_of(mode_i)) ? 1 : 0;
      check_eq(int'(tc_o), exp_tc, {tag, " tc"});
      if (!r)                              exp_cnt = start_of(mode_i);
      else if (!e)                         exp_cnt = exp_cnt;
      else if (exp_cnt == term_of(mode_i)) exp_cnt = start_of(mode_i);
      else                                 exp_cnt = (exp_cnt + 1) % 256;
      @(posedge clk);
      #1;
      check_eq(int'(count_o), exp_cnt, {tag, " count"});
   endtask

   task automatic t_reset();
      mode_i = 1'b0;
      cyc(1'b1, 1'b0, "R6 reset clear mode");
      check_eq(int'(count_o), 0, "R6 clear start");
      mode_i = 1'b1;
      cyc(1'b0, 1'b0, "R6 reset preload mode en low");
      check_eq(int'(count_o), START, "R6 preload start");
   endtask

   task automatic t_clear_run();
      int pulses = 0;
      mode_i = 1'b0;
      cyc(1'b1, 1'b0, "R6 reset");
      for (int i = 0; i < M; i++) begin
         #0;
         if (tc_o) begin
            pulses++;
            check_eq(int'(count_o), M - 1, "R7 count at terminal while tc");
         end
         cyc(1'b1, 1'b1, "R1 R2 clear run");
      end
      check_eq(pulses, 1, "R4 one pulse per modulus clear");
      check_eq(int'(count_o), 0, "R2 wrapped to zero");
   endtask

   task automatic t_preload_run();
      int pulses = 0;
      mode_i = 1'b1;
      cyc(1'b1, 1'b0, "R6 reset");
      check_eq(int'(count_o[7:4]), 3, "R3 high nibble");
      check_eq(int'(count_o[3:0]), 15, "R3 low nibble");
      for (int i = 0; i < M; i++) begin
         if (tc_o) begin
            pulses++;
            check_eq(int'(count_o), 255, "R7 count at terminal while tc");
         end
         cyc(1'b1, 1'b1, "R1 R3 preload run");
      end
      check_eq(pulses, 1, "R4 one pulse per modulus preload");
      check_eq(int'(count_o), START, "R3 reloaded start");
   endtask

   task automatic t_enable_hold();
      mode_i = 1'b0;
      cyc(1'b1, 1'b0, "R6 reset");
      for (int i = 0; i < 40; i++)
         cyc((i % 3) != 2, 1'b1, "R5 R1 gapped enable");
      while (exp_cnt != M - 1)
         cyc(1'b1, 1'b1, "R1 approach terminal");
      for (int i = 0; i < 3; i++)
         cyc(1'b0, 1'b1, "R5 hold at terminal");
      check_eq(int'(tc_o), 0, "R5 tc low while idle");
      cyc(1'b1, 1'b1, "R2 wrap after hold");
   endtask

   task automatic t_reset_collide();
      mode_i = 1'b1;
      cyc(1'b1, 1'b0, "R6 reset");
      for (int i = 0; i < 30; i++)
         cyc(1'b1, 1'b1, "R1 count");
      cyc(1'b0, 1'b0, "R6 reset beats hold");
      check_eq(int'(count_o), START, "R6 start after held reset");
      while (exp_cnt != 255)
         cyc(1'b1, 1'b1, "R1 approach full");
      cyc(1'b1, 1'b0, "R6 R4 reset at terminal");
      cyc(1'b1, 1'b1, "R4 no repeat pulse");
   endtask

   initial begin
      #1;
      t_reset();
      t_clear_run();
      t_preload_run();
      t_enable_hold();
      t_reset_collide();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(100000 * 4);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule